// File: doc/BRIEF.md
# Alternating Two-Slot DMA Request Controller

This block feeds a host DMA controller from a sample buffer, or feeds a DAC from host memory, through two request slots used in turn. Each slot is tied by software to one host DMA line number. The active slot raises its request line whenever there is work to do. On input that means the sample buffer reports data. On output it means a pacing tick from the sample timer is pending. Each acknowledge from the host produces a one-cycle strobe: a buffer read on input, a DAC write on output.

When the host signals terminal count on the active slot, that slot is marked as finished and an interrupt pulse is raised. In alternating mode the block then moves to the other slot, if software has armed it again. This lets one slot be reprogrammed while the other moves data, so the stream has no gap across segment boundaries. If the other slot is not armed, the block stops requesting and reports an underrun. A per-slot word counter ends a segment on its own once the segment word limit is reached. The index of the active slot is brought out so that software knows which slot it may reprogram.

Top module: `dual_dma_pingpong`

## Requirements
- R1: After reset, every request line is low, irq is low, underrun is low and active_slot is 0.
- R2: In input direction (dir_out=0), with enable high, the active slot armed and its line code valid, the request line whose index equals the active slot's line code is high exactly while buf_not_empty is high. At most one request line is high at any time.
- R3: An acknowledge is dack high on the line that is currently requesting. In the cycle after an acknowledge, every request line is low and exactly one strobe pulses for one cycle: buf_rd on input, dac_wr on output. A request may reappear no earlier than two cycles after the acknowledge.
- R4: In output direction (dir_out=1), requests are raised only for a pending pace_tick, and buf_not_empty has no effect. Each acknowledge consumes one pending tick. buf_rd and dac_wr are never high together.
- R5: An acknowledge with tc high ends the active slot's segment: irq pulses high for one cycle in the following cycle, and the finished slot is disarmed until arm_pulse sets it again.
- R6: At the end of a segment with dual_en high, if the other slot is armed, active_slot switches to it and requests continue on its line. If the other slot is not armed, underrun goes high and stays high, and no request is raised while it is high. With dual_en low, the block neither switches nor sets underrun.
- R7: active_slot (0 = slot A, 1 = slot B) changes only in the cycle after a segment end, or returns to 0 when enable is low.
- R8: Line codes 0 and 4 are invalid and never raise a request. xfer_wide equals bit 2 of the active slot's line code: it is 1 for the word-wide lines 5 to 7 and 0 for the byte-wide lines 1 to 3.
- R9: A slot whose word counter reaches MAX_WORDS acknowledges since it was last armed ends its segment as if tc had been seen on the last acknowledge.
- R10: While enable is low, no request is raised one cycle later. Disabling also clears underrun, the pending tick and active_slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Software run enable |
| dual_en | input | 1 | Alternate between the slots at each segment end |
| dir_out | input | 1 | 0: buffer to host, 1: host to DAC |
| code_a | input | 3 | Host DMA line number for slot A |
| code_b | input | 3 | Host DMA line number for slot B |
| arm_pulse | input | 2 | One-cycle pulse per slot: the slot has been reprogrammed (bit 0 = A) |
| buf_not_empty | input | 1 | Sample buffer holds data |
| pace_tick | input | 1 | Output pacing tick from the sample timer |
| dack | input | 8 | Host acknowledge, one bit per DMA line |
| tc | input | 1 | Host terminal count, valid with dack |
| drq | output | 8 | Request, one bit per DMA line |
| buf_rd | output | 1 | Read strobe to the sample buffer |
| dac_wr | output | 1 | Write strobe to the DAC |
| irq | output | 1 | One-cycle pulse at each segment end |
| underrun | output | 1 | Sticky: a segment ended and the other slot was not armed |
| active_slot | output | 1 | Index of the slot now in use |
| xfer_wide | output | 1 | The active line is word-wide |

## Verification
If the block held the wrong active slot or the wrong armed flag, the request would appear on the wrong drq bit, or not at all, within two cycles of a segment end. The alternation and underrun cases therefore check the request line and active_slot right after each terminal count. A broken strobe path shows up as a buf_rd or dac_wr pulse that is missing, extra or of the wrong kind in the cycle after an acknowledge. The bench matches every such pulse against the acknowledges it issued. A stale pacing or word-count state is caught by the request staying low, or rising, when the tick or word count says otherwise.

// File: rtl/dma_pp_pkg.sv
// Package: shared types and helpers for the alternating DMA request controller.
// Assumes host DMA line numbers are 3-bit codes; codes 0 and 4 are unusable.
package dma_pp_pkg;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } xfer_dir_e;

    // True for a line code that may carry requests.
    function automatic logic line_ok(input logic [2:0] code);
        return (code != 3'd0) && (code != 3'd4);
    endfunction

endpackage

// File: rtl/dma_slot_bank.sv
// Module: dma_slot_bank
// Holds, for each of the two slots, the armed flag and the count of words moved
// in the current segment. A slot is armed by software and disarmed when its
// segment ends. Reports when the active slot is on its final permitted word.
// Assumes ack_i and term_i refer to the slot selected by act_i.
module dma_slot_bank #(
    parameter int NSLOT     = 2,
    parameter int MAX_WORDS = 65536,
    localparam int CW       = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] arm_i,
    input  logic             ack_i,
    input  logic             term_i,
    input  logic             act_i,
    output logic [NSLOT-1:0] armed_o,
    output logic             last_word_o
);

    logic [CW-1:0] count_q [NSLOT];
    logic [NSLOT-1:0] last_vec;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic here;
        assign here = (act_i == s[0]);

        // Armed flag: set by software, cleared at this slot's segment end.
        always_ff @(posedge clk) begin
            if (!rst_n)                 armed_o[s] <= 1'b0;
            else if (arm_i[s])          armed_o[s] <= 1'b1;
            else if (term_i && here)    armed_o[s] <= 1'b0;
        end

        // Word counter: restarts on arming and on segment end.
        always_ff @(posedge clk) begin
            if (!rst_n)                         count_q[s] <= '0;
            else if (arm_i[s])                  count_q[s] <= '0;
            else if (ack_i && here && term_i)   count_q[s] <= '0;
            else if (ack_i && here)             count_q[s] <= count_q[s] + CW'(1);
        end

        assign last_vec[s] = (count_q[s] == CW'(MAX_WORDS - 1));
    end

    assign last_word_o = last_vec[act_i];

endmodule

// File: rtl/dma_pacer.sv
// Module: dma_pacer
// Decides whether the active direction has a word to move: buffer occupancy on
// input, a pending timer tick on output. A tick arriving together with a
// consumed tick leaves one tick pending.
module dma_pacer
    import dma_pp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_i,
    input  xfer_dir_e dir_i,
    input  logic      tick_i,
    input  logic      buf_ne_i,
    input  logic      consume_i,
    output logic      ready_o
);

    logic pend_q;

    // Pending-tick flag for the output direction.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)                 pend_q <= 1'b0;
        else if (tick_i && dir_i == DIR_OUT) pend_q <= 1'b1;
        else if (consume_i)                  pend_q <= 1'b0;
    end

    // Work-available select by direction.
    always_comb begin
        ready_o = (dir_i == DIR_OUT) ? pend_q : buf_ne_i;
    end

endmodule

// File: rtl/dma_req_engine.sv
// Module: dma_req_engine
// Sequences requests on the active slot: raises the request, detects the
// acknowledge, produces the strobe, ends segments, swaps slots and flags
// underrun. Assumes line codes stay stable while enabled.
module dma_req_engine
    import dma_pp_pkg::*;
#(
    parameter int NLINES  = 8,
    localparam int CODE_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              dual_i,
    input  xfer_dir_e         dir_i,
    input  logic              ready_i,
    input  logic [1:0]        armed_i,
    input  logic              last_word_i,
    input  logic [CODE_W-1:0] code_a_i,
    input  logic [CODE_W-1:0] code_b_i,
    input  logic [NLINES-1:0] dack_i,
    input  logic              tc_i,
    output logic              req_o,
    output logic              act_o,
    output logic [CODE_W-1:0] code_act_o,
    output logic              ack_o,
    output logic              term_o,
    output logic              underrun_o,
    output logic              irq_o,
    output logic              rd_o,
    output logic              wr_o
);

    logic req_d;
    logic run;

    // Active line code and acknowledge detection.
    always_comb begin
        code_act_o = act_o ? code_b_i : code_a_i;
        ack_o      = req_o && dack_i[code_act_o];
        term_o     = ack_o && (tc_i || last_word_i);
        run        = enable_i && !underrun_o;
        req_d      = run && armed_i[act_o] && line_ok(3'(code_act_o)) && ready_i
                     && !ack_o && !rd_o && !wr_o;
    end

    // Request, strobe and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o <= 1'b0;
            rd_o  <= 1'b0;
            wr_o  <= 1'b0;
            irq_o <= 1'b0;
        end else begin
            req_o <= req_d;
            rd_o  <= ack_o && (dir_i == DIR_IN);
            wr_o  <= ack_o && (dir_i == DIR_OUT);
            irq_o <= term_o;
        end
    end

    // Active slot selection and underrun detection at segment end.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            act_o      <= 1'b0;
            underrun_o <= 1'b0;
        end else if (term_o && dual_i) begin
            if (armed_i[~act_o]) act_o      <= ~act_o;
            else                 underrun_o <= 1'b1;
        end
    end

endmodule

// File: rtl/dual_dma_pingpong.sv
// Module: dual_dma_pingpong (top)
// Alternating two-slot DMA request controller. Joins the slot bank, the pacer
// and the request engine, and decodes the active line code into one request
// bit per host DMA line. Assumes the host controller is programmed before a
// slot is armed.
module dual_dma_pingpong
    import dma_pp_pkg::*;
#(
    parameter int NLINES    = 8,
    parameter int MAX_WORDS = 65536,
    localparam int CODE_W   = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              dual_en,
    input  logic              dir_out,
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    input  logic [1:0]        arm_pulse,
    input  logic              buf_not_empty,
    input  logic              pace_tick,
    input  logic [NLINES-1:0] dack,
    input  logic              tc,
    output logic [NLINES-1:0] drq,
    output logic              buf_rd,
    output logic              dac_wr,
    output logic              irq,
    output logic              underrun,
    output logic              active_slot,
    output logic              xfer_wide
);

    xfer_dir_e         dir;
    logic              ready;
    logic [1:0]        armed;
    logic              last_word;
    logic              req;
    logic              ack;
    logic              term;
    logic [CODE_W-1:0] code_act;

    assign dir = dir_out ? DIR_OUT : DIR_IN;

    dma_slot_bank #(.NSLOT(2), .MAX_WORDS(MAX_WORDS)) bank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm_pulse),
        .ack_i       (ack),
        .term_i      (term),
        .act_i       (active_slot),
        .armed_o     (armed),
        .last_word_o (last_word)
    );

    dma_pacer pacer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (!enable),
        .dir_i     (dir),
        .tick_i    (pace_tick),
        .buf_ne_i  (buf_not_empty),
        .consume_i (ack && dir == DIR_OUT),
        .ready_o   (ready)
    );

    dma_req_engine #(.NLINES(NLINES)) eng_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable),
        .dual_i      (dual_en),
        .dir_i       (dir),
        .ready_i     (ready),
        .armed_i     (armed),
        .last_word_i (last_word),
        .code_a_i    (code_a),
        .code_b_i    (code_b),
        .dack_i      (dack),
        .tc_i        (tc),
        .req_o       (req),
        .act_o       (active_slot),
        .code_act_o  (code_act),
        .ack_o       (ack),
        .term_o      (term),
        .underrun_o  (underrun),
        .irq_o       (irq),
        .rd_o        (buf_rd),
        .wr_o        (dac_wr)
    );

    // One request bit per host line, high only on the active line.
    for (genvar l = 0; l < NLINES; l++) begin : g_line
        assign drq[l] = req && (code_act == CODE_W'(l));
    end

    assign xfer_wide = code_act[CODE_W-1];

endmodule

// File: rtl/dma_pp_checker.sv
// Module: dma_pp_checker
// Property checks on the ports of dual_dma_pingpong, attached through bind.
module dma_pp_checker #(
    parameter int NLINES  = 8,
    localparam int CODE_W = $clog2(NLINES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [CODE_W-1:0] code_a,
    input logic [CODE_W-1:0] code_b,
    input logic [NLINES-1:0] dack,
    input logic [NLINES-1:0] drq,
    input logic              buf_rd,
    input logic              dac_wr,
    input logic              irq,
    input logic              underrun,
    input logic              active_slot
);

    logic [CODE_W-1:0] cur_code;
    assign cur_code = active_slot ? code_b : code_a;

    AST_DRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(drq)); // R2
    AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n) (|(dack & drq)) |=> (drq == '0)); // R3
    AST_STROBE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n) (|(dack & drq)) |=> (buf_rd || dac_wr)); // R3
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(buf_rd && dac_wr)); // R4
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R5
    AST_NO_REQ_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n) underrun |-> (drq == '0)); // R6
    AST_BAD_CODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) ((cur_code == CODE_W'(0)) || (cur_code == CODE_W'(4))) |-> (drq == '0)); // R8
    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> (drq == '0)); // R10

endmodule

bind dual_dma_pingpong dma_pp_checker #(.NLINES(NLINES)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .code_a      (code_a),
    .code_b      (code_b),
    .dack        (dack),
    .drq         (drq),
    .buf_rd      (buf_rd),
    .dac_wr      (dac_wr),
    .irq         (irq),
    .underrun    (underrun),
    .active_slot (active_slot)
);

// File: tb/dual_dma_pingpong_tb_top.sv
// Bench: scoreboard of expected strobes pushed by the acknowledge driver and
// popped by a monitor; direct checks on request lines, irq and status.
module dual_dma_pingpong_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       enable, dual_en, dir_out;
    logic [2:0] code_a, code_b;
    logic [1:0] arm_pulse;
    logic       buf_not_empty, pace_tick, tc;
    logic [7:0] dack, drq;
    logic       buf_rd, dac_wr, irq, underrun, active_slot, xfer_wide;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    bit  exp_q [$];   // 0: buffer read expected, 1: DAC write expected

    always #10 clk = ~clk;   // 50 MHz

    dual_dma_pingpong #(.NLINES(8), .MAX_WORDS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dual_en(dual_en),
        .dir_out(dir_out), .code_a(code_a), .code_b(code_b),
        .arm_pulse(arm_pulse), .buf_not_empty(buf_not_empty),
        .pace_tick(pace_tick), .dack(dack), .tc(tc), .drq(drq),
        .buf_rd(buf_rd), .dac_wr(dac_wr), .irq(irq), .underrun(underrun),
        .active_slot(active_slot), .xfer_wide(xfer_wide)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input logic [1:0] m);
        arm_pulse = m;
        cyc(1);
        arm_pulse = 2'b00;
    endtask

    // Waits for the request on line c, acknowledges it, expects the strobe.
    task automatic do_ack(input int c, input bit with_tc, input bit is_wr, input string req);
        int t = 0;
        while (!drq[c] && t < 20) begin cyc(1); t++; end
        check(drq[c], req, drq, 8'(1 << c));
        dack[c] = 1'b1;
        tc      = with_tc;
        exp_q.push_back(is_wr);
        cyc(1);
        dack = '0;
        tc   = 1'b0;
        check(drq == 8'h00, "R3", drq, 0);
    endtask

    // Scoreboard monitor: every strobe must match an issued acknowledge.
    always @(negedge clk) begin
        if (rst_n && (buf_rd || dac_wr)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", {buf_rd, dac_wr}, 0);
            end else begin
                bit w;
                w = exp_q.pop_front();
                check(dac_wr == w && buf_rd == !w, w ? "R4" : "R3", {buf_rd, dac_wr}, w ? 1 : 2);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; dual_en = 1'b0; dir_out = 1'b0;
        code_a = 3'd0; code_b = 3'd0; arm_pulse = 2'b00;
        buf_not_empty = 1'b0; pace_tick = 1'b0; tc = 1'b0; dack = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check(drq == 0 && irq == 0 && underrun == 0 && active_slot == 0, "R1",
              {drq, irq, underrun, active_slot}, 0);

        // R8: invalid line code on slot A never requests.
        code_a = 3'd4; code_b = 3'd6; dual_en = 1'b1;
        arm(2'b11);
        enable = 1'b1; buf_not_empty = 1'b1;
        cyc(3);
        check(drq == 8'h00, "R8", drq, 0);

        // R2: valid word-wide line requests while buffer has data.
        code_a = 3'd5;
        cyc(3);
        check(drq == 8'h20, "R2", drq, 8'h20);
        check(xfer_wide == 1'b1, "R8", xfer_wide, 1);
        buf_not_empty = 1'b0;
        cyc(2);
        check(drq == 8'h00, "R2", drq, 0);
        buf_not_empty = 1'b1;
        cyc(2);

        // R3: acknowledge, gap, request again.
        do_ack(5, 1'b0, 1'b0, "R3");
        cyc(1);
        check(drq == 8'h00, "R3", drq, 0);
        cyc(1);
        check(drq == 8'h20, "R3", drq, 8'h20);

        // R5 / R6 / R7: segment end swaps to armed slot B.
        do_ack(5, 1'b1, 1'b0, "R5");
        check(irq == 1'b1, "R5", irq, 1);
        check(active_slot == 1'b1, "R7", active_slot, 1);
        cyc(1);
        check(irq == 1'b0, "R5", irq, 0);
        cyc(1);
        check(drq == 8'h40, "R6", drq, 8'h40);

        // R6: slot A not re-armed, so segment end on B is an underrun.
        do_ack(6, 1'b1, 1'b0, "R6");
        check(underrun == 1'b1 && irq == 1'b1, "R6", {underrun, irq}, 3);
        check(active_slot == 1'b1, "R7", active_slot, 1);
        cyc(3);
        check(drq == 8'h00, "R6", drq, 0);

        // R10: disable clears status.
        enable = 1'b0;
        cyc(2);
        check(underrun == 1'b0 && active_slot == 1'b0 && drq == 0, "R10",
              {drq, underrun, active_slot}, 0);

        // R4: output direction paced by ticks, buffer flag ignored.
        dir_out = 1'b1; code_a = 3'd1;
        arm(2'b01);
        enable = 1'b1;
        cyc(4);
        check(drq == 8'h00, "R4", drq, 0);
        check(xfer_wide == 1'b0, "R8", xfer_wide, 0);
        pace_tick = 1'b1;
        cyc(1);
        pace_tick = 1'b0;
        cyc(1);
        check(drq == 8'h02, "R4", drq, 8'h02);
        do_ack(1, 1'b0, 1'b1, "R4");
        cyc(4);
        check(drq == 8'h00, "R4", drq, 0);

        // R9: word limit ends a segment without tc.
        enable = 1'b0; dir_out = 1'b0; code_a = 3'd5; code_b = 3'd7;
        cyc(1);
        arm(2'b11);
        enable = 1'b1;
        for (int i = 0; i < 3; i++) begin
            do_ack(5, 1'b0, 1'b0, "R9");
            check(irq == 1'b0 && active_slot == 1'b0, "R9", {irq, active_slot}, 0);
        end
        do_ack(5, 1'b0, 1'b0, "R9");
        check(irq == 1'b1 && active_slot == 1'b1, "R9", {irq, active_slot}, 3);
        cyc(2);
        check(drq == 8'h80, "R9", drq, 8'h80);

        // R6: with dual_en low, segment end neither swaps nor flags underrun.
        enable = 1'b0; dual_en = 1'b0;
        cyc(1);
        arm(2'b11);
        enable = 1'b1;
        do_ack(5, 1'b1, 1'b0, "R6");
        check(irq == 1'b1 && active_slot == 1'b0 && underrun == 1'b0, "R6",
              {irq, active_slot, underrun}, 4);
        cyc(3);
        check(drq == 8'h00, "R6", drq, 0);

        cyc(2);
        check(exp_q.size() == 0, "R3", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule